// File: doc/BRIEF.md
# Framed Word/Byte Serial Codec Port

This block is the digital half of a voice-band converter's synchronous serial link to a signal processor. From the master clock it derives a shift clock at one quarter of the master rate. For each converter sample it runs one frame. The frame shifts the sample out on the receive data line under an active-low receive frame sync. In the same shift periods it collects a 16-bit word from the processor on the transmit data line under an active-low transmit frame sync. Active-low end-of-data strobes tell the processor when a transfer has finished or which byte it is looking at.

A mode input picks between one 16-bit transfer and two 8-bit transfers per frame, sent most significant byte first. A collected word whose two low bits are both 1 asks for a secondary frame to follow. That frame carries only a control word from the processor. No receive framing, receive strobe or receive data appears during it. A conversion-sample stream is the input handshake. Samples are accepted with valid/ready: ready is high only while no frame is running or waiting, and the sample must be held with valid high until ready is seen. The collected word leaves as a one-cycle valid pulse with no back-pressure. The serial timing cannot stall, so the consumer must take the word in that cycle.

Top module: `vbsp_port`

## Requirements
- R1: `sclk` is the master clock divided by DIV (default 4), high for the first DIV/2 master cycles of each shift period. During reset `sclk` is high, all four frame and strobe outputs are high, `word_valid` is low and `smp_ready` is low.
- R2: After reset a primary frame with an all-zero receive word runs without any sample. `smp_ready` is high only while no frame is running or pending, and not in the cycle `word_valid` is high. A sample is accepted in a cycle where both `smp_valid` and `smp_ready` are high.
- R3: An accepted 14-bit two's complement sample is sent as word `{sample, 2'b00}`, MSB first. Its MSB is on `dr` from the cycle after acceptance, through a full lead period with the frame syncs high, before `fsr_n` falls. `dr` changes only at shift-period boundaries and is 0 once all bits are out.
- R4: In word mode a frame is one lead period, then 16 shift periods with `fsx_n` and `fsr_n` both low. The frame starts at the first shift-period boundary after a request. Frame syncs change only when `sclk` rises. `dx` is sampled in the last master cycle of each low period.
- R5: In word mode `eodx_n` and `eodr_n` go low together for exactly one shift period right after the 16th bit period.
- R6: In byte mode a frame is one lead period, then 8 shift periods of frame sync low, then one period with the frame syncs high, then 8 more low periods. The upper byte goes first in both directions.
- R7: In byte mode the end-of-data strobes go low when the first byte ends and stay low through the gap and the whole second byte. They rise right after the last bit period.
- R8: `word_valid` pulses for one master cycle, in the first cycle after the transmit end-of-data indication ends. `word_data` then holds the 16 `dx` bits MSB first, and `word_sec` tells whether the frame was a secondary one.
- R9: A primary word whose bits 1:0 are 2'b11 makes the next frame secondary. In that frame `fsx_n` and `eodx_n` behave as in a primary frame of the same mode, while `fsr_n` and `eodr_n` stay high and `dr` stays 0. The code bits of a secondary word are ignored, so no further secondary frame follows.
- R10: `byte_mode` is taken once, at the start of a frame's lead period. Changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 selects two 8-bit transfers per frame, 0 one 16-bit transfer |
| smp_valid | input | 1 | Converter sample available |
| smp_ready | output | 1 | Port can accept a sample |
| smp_data | input | SMP_W (14) | Two's complement converter sample |
| sclk | output | 1 | Shift clock |
| fsx_n | output | 1 | Transmit frame sync, active low |
| fsr_n | output | 1 | Receive frame sync, active low |
| dx | input | 1 | Serial data from the processor |
| dr | output | 1 | Serial data to the processor |
| eodx_n | output | 1 | Transmit end-of-data strobe, active low |
| eodr_n | output | 1 | Receive end-of-data strobe, active low |
| word_valid | output | 1 | One-cycle pulse: collected word available |
| word_data | output | WORD_W (16) | Collected word: DAC data in 15:2, request code in 1:0 |
| word_sec | output | 1 | Collected word came from a secondary frame |

## Verification
The bench goes after the byte-mode gap. A design that let the strobes bounce high between bytes, or kept the frame syncs low across the gap, would merge the two bytes into one. It also goes after secondary frames. A design that leaked a receive frame sync or strobe there would make the processor read a phantom sample. A design that obeyed the code bits of a secondary word would run secondary frames without end. Three more cases are checked: a `byte_mode` change in the middle of a frame, which a design that kept following the input would act on halfway through; a sample offered while the port is busy, or in the cycle a word is handed out; and the frame the port runs by itself after reset, which a design waiting for a sample would never produce.

// File: rtl/vbsp_pkg.sv
package vbsp_pkg;
  // Frame sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_GAP,
    ST_EOD
  } seq_state_t;

  // Width and value of the request code in the low bits of a collected word
  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] SEC_REQ = 2'b11;
endpackage

// File: rtl/vbsp_clkdiv.sv
module vbsp_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] PH_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] PH_HALF = CW'(DIV / 2);

  logic [CW-1:0] ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (ph == PH_LAST) begin
      ph <= '0;
    end else begin
      ph <= ph + CW'(1);
    end
  end

  // High in the first half of each period; tick marks the period's last cycle
  assign sclk = (ph < PH_HALF);
  assign tick = (ph == PH_LAST);
endmodule

// File: rtl/vbsp_seq.sv
module vbsp_seq
  import vbsp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic byte_mode,
  input  logic req_pri,
  input  logic req_sec,
  output logic start,
  output logic shift_en,
  output logic done,
  output logic idle,
  output logic cur_sec,
  output logic fsx_n,
  output logic fsr_n,
  output logic eodx_n,
  output logic eodr_n
);
  localparam int HALF_W = WORD_W / 2;
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_WORD = CW'(WORD_W - 1);
  localparam logic [CW-1:0] LAST_HALF = CW'(HALF_W - 1);

  seq_state_t st;
  logic [CW-1:0] cnt;
  logic byte_q;
  logic second;
  logic seg_last;
  logic in_shift;
  logic eod_low;

  assign seg_last = byte_q ? (cnt == LAST_HALF) : (cnt == LAST_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      byte_q  <= 1'b0;
      second  <= 1'b0;
      cur_sec <= 1'b0;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          if (req_sec || req_pri) begin
            st      <= ST_LEAD;
            cur_sec <= req_sec;
            byte_q  <= byte_mode;
          end
        end
        ST_LEAD: begin
          st     <= ST_SHIFT;
          cnt    <= '0;
          second <= 1'b0;
        end
        ST_SHIFT: begin
          cnt <= cnt + CW'(1);
          if (seg_last) begin
            if (!byte_q) begin
              st <= ST_EOD;
            end else if (!second) begin
              st <= ST_GAP;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          st     <= ST_SHIFT;
          cnt    <= '0;
          second <= 1'b1;
        end
        ST_EOD:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle     = (st == ST_IDLE);
  assign start    = tick && idle && (req_sec || req_pri);
  assign shift_en = tick && (st == ST_SHIFT);
  assign done     = tick && ((st == ST_EOD) ||
                             ((st == ST_SHIFT) && seg_last && byte_q && second));

  assign in_shift = (st == ST_SHIFT);
  assign eod_low  = (st == ST_EOD) ||
                    (byte_q && ((st == ST_GAP) || ((st == ST_SHIFT) && second)));

  assign fsx_n  = !in_shift;
  assign fsr_n  = !(in_shift && !cur_sec);
  assign eodx_n = !eod_low;
  assign eodr_n = !(eod_low && !cur_sec);
endmodule

// File: rtl/vbsp_shift.sv
module vbsp_shift #(
  parameter int WORD_W = 16,
  parameter int SMP_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SMP_W-1:0]  load_data,
  input  logic              shift_en,
  input  logic              dx,
  output logic              dr,
  output logic [WORD_W-1:0] word_data
);
  localparam int PAD_W = WORD_W - SMP_W;

  logic [WORD_W-1:0] rx_sr;
  logic [WORD_W-1:0] tx_sr;

  // Outgoing sample register: loaded on acceptance, empties to zero as it shifts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sr <= '0;
    end else if (load) begin
      rx_sr <= {load_data, {PAD_W{1'b0}}};
    end else if (shift_en) begin
      rx_sr <= {rx_sr[WORD_W-2:0], 1'b0};
    end
  end

  // Incoming word register: holds its value between frames
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (shift_en) begin
      tx_sr <= {tx_sr[WORD_W-2:0], dx};
    end
  end

  assign dr        = rx_sr[WORD_W-1];
  assign word_data = tx_sr;
endmodule

// File: rtl/vbsp_port.sv
module vbsp_port
  import vbsp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SMP_W  = 14,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              sclk,
  output logic              fsx_n,
  output logic              fsr_n,
  input  logic              dx,
  output logic              dr,
  output logic              eodx_n,
  output logic              eodr_n,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_sec
);
  logic tick;
  logic start;
  logic shift_en;
  logic done;
  logic idle;
  logic cur_sec;
  logic pend;
  logic sec_pend;
  logic done_q;
  logic accept;

  vbsp_clkdiv #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .tick  (tick)
  );

  vbsp_seq #(.WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .byte_mode (byte_mode),
    .req_pri   (pend),
    .req_sec   (sec_pend),
    .start     (start),
    .shift_en  (shift_en),
    .done      (done),
    .idle      (idle),
    .cur_sec   (cur_sec),
    .fsx_n     (fsx_n),
    .fsr_n     (fsr_n),
    .eodx_n    (eodx_n),
    .eodr_n    (eodr_n)
  );

  vbsp_shift #(.WORD_W(WORD_W), .SMP_W(SMP_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (smp_data),
    .shift_en  (shift_en),
    .dx        (dx),
    .dr        (dr),
    .word_data (word_data)
  );

  assign smp_ready = idle && !pend && !sec_pend && !done_q;
  assign accept    = smp_valid && smp_ready;

  // Reset leaves a primary frame pending so the link starts by itself
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b1;
      sec_pend <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done;
      if (start) begin
        if (sec_pend) begin
          sec_pend <= 1'b0;
        end else begin
          pend <= 1'b0;
        end
      end else if (accept) begin
        pend <= 1'b1;
      end
      if (done_q && !cur_sec && (word_data[CODE_W-1:0] == SEC_REQ)) begin
        sec_pend <= 1'b1;
      end
    end
  end

  assign word_valid = done_q;
  assign word_sec   = cur_sec;
endmodule

// File: rtl/vbsp_chk.sv
module vbsp_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_ready,
  input logic sclk,
  input logic fsx_n,
  input logic fsr_n,
  input logic dr,
  input logic eodx_n,
  input logic eodr_n,
  input logic word_valid
);
  // R4
  fs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fsr_n |-> !fsx_n);

  // R4
  fs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsx_n) |-> $rose(sclk));

  // R3
  msb_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsr_n) |-> $stable(dr));

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fsx_n |-> !smp_ready);

  // R8
  one_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R8
  valid_after_eod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (eodx_n && fsx_n));

  // R9
  sec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_n && !fsx_n) |-> eodr_n);
endmodule

bind vbsp_port vbsp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_ready  (smp_ready),
  .sclk       (sclk),
  .fsx_n      (fsx_n),
  .fsr_n      (fsr_n),
  .dr         (dr),
  .eodx_n     (eodx_n),
  .eodr_n     (eodr_n),
  .word_valid (word_valid)
);

// File: tb/vbsp_port_test.sv
module vbsp_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_mode;
  logic        smp_valid;
  logic        smp_ready;
  logic [13:0] smp_data;
  logic        sclk, fsx_n, fsr_n, dr, eodx_n, eodr_n;
  logic        dx = 1'b1;
  logic        word_valid, word_sec;
  logic [15:0] word_data;

  always #10 clk = ~clk;

  vbsp_port uut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .sclk(sclk), .fsx_n(fsx_n), .fsr_n(fsr_n), .dx(dx), .dr(dr),
    .eodx_n(eodx_n), .eodr_n(eodr_n),
    .word_valid(word_valid), .word_data(word_data), .word_sec(word_sec)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit r10_active = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // Expected waveform of one shift period
  typedef struct packed {
    logic fsx, fsr, eodx, eodr, dr, smp, dxb, last;
  } per_t;

  per_t        fq[$];
  per_t        cur;
  bit          cur_v;
  logic [15:0] dsp_q[$];
  int          m_ph;
  bit          m_pend, m_sec, m_wv, m_cursec, m_bframe;
  logic [15:0] m_rx, m_word;

  function automatic bit exp_ready();
    return !cur_v && !m_pend && !m_sec && !m_wv;
  endfunction

  task automatic build(input logic [15:0] r, input logic [15:0] t,
                       input bit bm, input bit s);
    per_t p;
    p = '{fsx:1'b1, fsr:1'b1, eodx:1'b1, eodr:1'b1, dr:(s ? 1'b0 : r[15]),
          smp:1'b0, dxb:1'b0, last:1'b0};
    fq.push_back(p);
    if (!bm) begin
      for (int k = 0; k < 16; k++) begin
        p = '{fsx:1'b0, fsr:s, eodx:1'b1, eodr:1'b1, dr:(s ? 1'b0 : r[15-k]),
              smp:1'b1, dxb:t[15-k], last:1'b0};
        fq.push_back(p);
      end
      p = '{fsx:1'b1, fsr:1'b1, eodx:1'b0, eodr:s, dr:1'b0,
            smp:1'b0, dxb:1'b0, last:1'b1};
      fq.push_back(p);
    end else begin
      for (int k = 0; k < 8; k++) begin
        p = '{fsx:1'b0, fsr:s, eodx:1'b1, eodr:1'b1, dr:(s ? 1'b0 : r[15-k]),
              smp:1'b1, dxb:t[15-k], last:1'b0};
        fq.push_back(p);
      end
      p = '{fsx:1'b1, fsr:1'b1, eodx:1'b0, eodr:s, dr:(s ? 1'b0 : r[7]),
            smp:1'b0, dxb:1'b0, last:1'b0};
      fq.push_back(p);
      for (int k = 0; k < 8; k++) begin
        p = '{fsx:1'b0, fsr:s, eodx:1'b0, eodr:s, dr:(s ? 1'b0 : r[7-k]),
              smp:1'b1, dxb:t[7-k], last:(k == 7)};
        fq.push_back(p);
      end
    end
  endtask

  // Reference model: advances one master cycle per edge
  always @(posedge clk) begin
    bit acc;
    bit nwv;
    logic [15:0] t;
    if (!rst_n) begin
      m_ph = 0; m_pend = 1; m_sec = 0; m_rx = '0; cur_v = 0; fq.delete();
      m_wv = 0; m_cursec = 0; m_bframe = 0; m_word = '0;
    end else begin
      acc = smp_valid && exp_ready();
      nwv = 0;
      if (m_wv && !m_cursec && (m_word[1:0] == 2'b11)) m_sec = 1;
      if (m_ph == 3) begin
        if (cur_v && cur.last) nwv = 1;
        if (cur_v) begin
          if (fq.size() > 0) cur = fq.pop_front();
          else cur_v = 0;
        end else if (m_sec || m_pend) begin
          t = (dsp_q.size() > 0) ? dsp_q.pop_front() : 16'h0000;
          m_cursec = m_sec;
          m_bframe = byte_mode;
          m_word   = t;
          build(m_sec ? 16'h0000 : m_rx, t, byte_mode, m_sec);
          if (m_sec) m_sec = 0; else m_pend = 0;
          cur   = fq.pop_front();
          cur_v = 1;
        end
      end
      if (acc) begin
        m_pend = 1;
        m_rx   = {smp_data, 2'b00};
      end
      m_wv = nwv;
      m_ph = (m_ph + 1) % 4;
    end
  end

  // Processor side: drives dx in the bit periods, 1 elsewhere
  always @(negedge clk) begin
    dx <= (rst_n && cur_v && cur.smp) ? cur.dxb : 1'b1;
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    logic e_fsx, e_fsr, e_eodx, e_eodr, e_dr;
    string fs_tag, eod_tag;
    if (rst_n && !finished) begin
      e_fsx  = cur_v ? cur.fsx  : 1'b1;
      e_fsr  = cur_v ? cur.fsr  : 1'b1;
      e_eodx = cur_v ? cur.eodx : 1'b1;
      e_eodr = cur_v ? cur.eodr : 1'b1;
      e_dr   = cur_v ? cur.dr   : (m_pend ? m_rx[15] : 1'b0);
      fs_tag  = r10_active ? "R10" : (m_bframe ? "R6" : "R4");
      eod_tag = r10_active ? "R10" : (m_bframe ? "R7" : "R5");
      chk(sclk === (m_ph < 2), "R1", "sclk", {15'b0, sclk}, {15'b0, (m_ph < 2)});
      chk(fsx_n === e_fsx, fs_tag, "fsx_n", {15'b0, fsx_n}, {15'b0, e_fsx});
      chk(fsr_n === e_fsr, m_cursec ? "R9" : fs_tag, "fsr_n", {15'b0, fsr_n}, {15'b0, e_fsr});
      chk(eodx_n === e_eodx, eod_tag, "eodx_n", {15'b0, eodx_n}, {15'b0, e_eodx});
      chk(eodr_n === e_eodr, m_cursec ? "R9" : eod_tag, "eodr_n", {15'b0, eodr_n}, {15'b0, e_eodr});
      chk(dr === e_dr, m_cursec ? "R9" : "R3", "dr", {15'b0, dr}, {15'b0, e_dr});
      chk(smp_ready === exp_ready(), "R2", "smp_ready", {15'b0, smp_ready}, {15'b0, exp_ready()});
      chk(word_valid === m_wv, "R8", "word_valid", {15'b0, word_valid}, {15'b0, m_wv});
      if (m_wv) begin
        chk(word_data === m_word, "R8", "word_data", word_data, m_word);
        chk(word_sec === m_cursec, "R9", "word_sec", {15'b0, word_sec}, {15'b0, m_cursec});
      end
    end
  end

  task automatic send(input logic [13:0] d, input logic [15:0] w1,
                      input bit with_sec, input logic [15:0] w2);
    dsp_q.push_back(w1);
    if (with_sec) dsp_q.push_back(w2);
    smp_data  = d;
    smp_valid = 1'b1;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data  = 14'h3C3C;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!exp_ready()) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      chk(1'b0, "R4", "watchdog expired", 16'h0, 16'h1);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; byte_mode = 1'b0; smp_valid = 1'b0; smp_data = '0;
    dsp_q.push_back(16'h1234);
    repeat (3) @(negedge clk);
    // R1: reset state, R2: no sample accepted during reset
    chk(sclk === 1'b1, "R1", "reset sclk", {15'b0, sclk}, 16'h1);
    chk({fsx_n, fsr_n, eodx_n, eodr_n} === 4'hF, "R1", "reset frame lines",
        {12'b0, fsx_n, fsr_n, eodx_n, eodr_n}, 16'h000F);
    chk(word_valid === 1'b0, "R1", "reset word_valid", {15'b0, word_valid}, 16'h0);
    chk(smp_ready === 1'b0, "R2", "reset smp_ready", {15'b0, smp_ready}, 16'h0);
    rst_n = 1'b1;

    // R2: the self-started frame runs; word mode transfers (R3, R4, R5, R8)
    wait_idle();
    send(14'h2AB5, 16'hA5A4, 0, 16'h0);
    send(14'h1FFF, 16'hFFFC, 0, 16'h0);
    send(14'h2000, 16'h0001, 0, 16'h0);
    send(14'h0000, 16'h8002, 0, 16'h0);
    // R9: secondary after a word-mode primary; its own code 11 is ignored
    send(14'h0F0F, 16'hC0D3, 1, 16'h5A5B);
    wait_idle();

    // R6, R7: byte mode, then a byte-mode secondary (R9)
    byte_mode = 1'b1;
    send(14'h35C1, 16'h9C3A, 0, 16'h0);
    send(14'h0A5A, 16'h7E81, 0, 16'h0);
    send(14'h1234, 16'hBEEF, 1, 16'hFFFF);
    wait_idle();

    // R10: mode changed while a word-mode frame runs
    byte_mode = 1'b0;
    send(14'h2C3D, 16'h6B24, 0, 16'h0);
    while (fsx_n) @(negedge clk);
    r10_active = 1'b1;
    byte_mode  = 1'b1;
    wait_idle();
    r10_active = 1'b0;
    // and the reverse: byte-mode frame with the input dropped mid-frame
    send(14'h13F0, 16'h4C1D, 0, 16'h0);
    while (fsx_n) @(negedge clk);
    r10_active = 1'b1;
    byte_mode  = 1'b0;
    wait_idle();
    r10_active = 1'b0;

    repeat (40) @(negedge clk);
    summary();
  end
endmodule